// File: doc/BRIEF.md
# Multiblock Fire-Code Parity Encoder

This block produces the 26-bit burst-correcting parity word for one multiblock of a 64b/66b-style serial link. Each multiblock holds 32 scrambled 64-bit blocks, which is 2048 payload bits. Sync header bits are not part of the input. The encoder divides the payload by the generator polynomial of a shortened (2074, 2048) cyclic code. That code is cut down from the (8687, 8661) Fire code and can repair any single error burst of up to 9 bits per multiblock. The division runs one whole 64-bit block per clock.

The upstream framer marks the first block of every multiblock with a start flag. The encoder accepts blocks only while the block-valid input is high. When it takes the last block of a multiblock, it releases the parity word with a one-cycle valid strobe and clears its remainder. The transmit path carries that word in the sync header stream of the following multiblock. A start flag that arrives part-way through a multiblock abandons the partial result, and the encoder begins again from zero.

The controller has two states:
- `ST_IDLE` waits for a start-flagged block.
- `ST_ACCUM` accumulates blocks.

It has these transitions:
- **open**: `ST_IDLE` to `ST_ACCUM`, on a valid block with the start flag.
- **advance**: `ST_ACCUM` to `ST_ACCUM`, on a valid block that is not the last one.
- **restart**: `ST_ACCUM` to `ST_ACCUM`, on a valid block with the start flag. The count resets to 1.
- **close**: `ST_ACCUM` to `ST_IDLE`, on the valid block that completes the multiblock.
- **wait**: no change of state, on any cycle without an accepted block.

Top module: `fec_parity_enc`

## Requirements
- R1: The parity word equals the remainder of x^26·M(x) divided by g(x) = x^26 + x^21 + x^17 + x^9 + x^4 + 1. The highest-order coefficient of M(x) is the first payload bit. Within a block, bit 63 enters first and bit 0 enters last, and blocks enter in arrival order. Parity bit 25 is the coefficient of x^25.
- R2: The remainder starts from zero for every multiblock, so a multiblock's parity does not depend on any earlier multiblock.
- R3: `par_valid` is high for exactly one cycle. That cycle is the one that follows the clock edge at which the 32nd block of a multiblock is accepted.
- R4: `par_word` keeps its value in every cycle where `par_valid` is low, and changes only when a new parity word is released.
- R5: A cycle with `blk_valid` low does not change the remainder or the block count, whatever `blk_data` and `mb_start` hold.
- R6: A block with both `blk_valid` and `mb_start` high, arriving inside a multiblock, drops the partial result and becomes block 1 of a new multiblock. No parity is released for the abandoned multiblock.
- R7: While no multiblock is open, valid blocks without `mb_start` are ignored.
- R8: `mb_start` is ignored when `blk_valid` is low.
- R9: After reset, `par_valid` and `par_word` are 0 and no multiblock is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A payload block is present on `blk_data` this cycle |
| mb_start | input | 1 | The present block is the first block of a multiblock |
| blk_data | input | 64 | Scrambled payload block; bit 63 is divided first |
| par_valid | output | 1 | One-cycle strobe when a new parity word is released |
| par_word | output | 26 | Parity of the most recently completed multiblock |

## Verification
The bench builds the encoder with its default parameters: 64-bit blocks, 32 blocks per multiblock and the 26-bit Fire polynomial. With these values the full 2048-bit division and the real 32-block count boundary are exercised, including a restart flag that lands on the very block that would have closed a multiblock. The reference model collects the payload in a bit queue and runs a textbook long division at close time. A wrong tap, a wrong bit order or a wrong count limit therefore shows up as a word mismatch on the strobe cycle.

// File: rtl/fec_pkg.sv
package fec_pkg;

    // Controller states of the multiblock parity encoder
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } fec_state_e;

endpackage

// File: rtl/fec_div_step.sv
// Combinational division of the running remainder by the generator polynomial,
// DATA_W input bits per call, most significant input bit first.
module fec_div_step #(
    parameter int             DATA_W = 64,
    parameter int             PAR_W  = 26,
    parameter logic [PAR_W-1:0] POLY = 26'h0220211
) (
    input  logic [PAR_W-1:0]  rem_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [PAR_W-1:0]  rem_out
);

    logic [DATA_W:0][PAR_W-1:0] chain;

    assign chain[0] = rem_in;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic fb;
        assign fb           = chain[i][PAR_W-1] ^ data_in[DATA_W-1-i];
        assign chain[i+1]   = {chain[i][PAR_W-2:0], 1'b0} ^ ({PAR_W{fb}} & POLY);
    end

    assign rem_out = chain[DATA_W];

endmodule

// File: rtl/fec_blk_counter.sv
// Counts the blocks already taken into the open multiblock.
module fec_blk_counter #(
    parameter int BLOCKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic first,
    input  logic finish,
    output logic cnt_last
);

    localparam int                CNT_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BLOCKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (finish) begin
            cnt <= '0;
        end else if (first) begin
            cnt <= CNT_W'(1);
        end else if (take) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign cnt_last = (cnt == LAST);

    // R5: an idle cycle leaves the count alone
    a_r5_cnt_still: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cnt));

    // R6: a start-flagged block that does not close leaves exactly one block counted
    a_r6_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (first && !finish) |=> (cnt == CNT_W'(1)));

endmodule

// File: rtl/fec_ctrl.sv
// Multiblock controller: decides which blocks are taken, restarted and closed.
module fec_ctrl
    import fec_pkg::*;
#(
    parameter int BLOCKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_valid,
    input  logic mb_start,
    input  logic cnt_last,
    output logic take,
    output logic first,
    output logic finish,
    output logic in_mb
);

    localparam bit SINGLE = (BLOCKS == 1);

    fec_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (blk_valid && mb_start) begin
                    state_d = SINGLE ? ST_IDLE : ST_ACCUM;      // open
                end
            end
            ST_ACCUM: begin
                if (blk_valid && mb_start) begin
                    state_d = SINGLE ? ST_IDLE : ST_ACCUM;      // restart
                end else if (blk_valid && cnt_last) begin
                    state_d = ST_IDLE;                          // close
                end else begin
                    state_d = ST_ACCUM;                         // advance / wait
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take   = 1'b0;
        first  = 1'b0;
        finish = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                take   = blk_valid && mb_start;
                first  = blk_valid && mb_start;
                finish = blk_valid && mb_start && SINGLE;
            end
            ST_ACCUM: begin
                take   = blk_valid;
                first  = blk_valid && mb_start;
                finish = blk_valid && (mb_start ? SINGLE : cnt_last);
            end
            default: ;
        endcase
    end

    assign in_mb = (state_q == ST_ACCUM);

    // R7: in idle, only start-flagged blocks are taken
    a_r7_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_mb && blk_valid && !mb_start) |=> (in_mb == $past(in_mb)));

    // R8: a start flag without a valid block does not open a multiblock
    a_r8_start_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_mb && !blk_valid) |=> !in_mb);

endmodule

// File: rtl/fec_remainder.sv
// Holds the running remainder; zero at the start of each multiblock.
module fec_remainder #(
    parameter int               DATA_W = 64,
    parameter int               PAR_W  = 26,
    parameter logic [PAR_W-1:0] POLY   = 26'h0220211
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              first,
    input  logic              finish,
    input  logic [DATA_W-1:0] data,
    output logic [PAR_W-1:0]  rem_next,
    output logic [PAR_W-1:0]  rem_q
);

    logic [PAR_W-1:0] rem_base;

    assign rem_base = first ? '0 : rem_q;

    fec_div_step #(
        .DATA_W (DATA_W),
        .PAR_W  (PAR_W),
        .POLY   (POLY)
    ) i_step (
        .rem_in  (rem_base),
        .data_in (data),
        .rem_out (rem_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (finish) begin
            rem_q <= '0;
        end else if (take) begin
            rem_q <= rem_next;
        end
    end

    // R5: no block taken, remainder unchanged
    a_r5_rem_still: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(rem_q));

endmodule

// File: rtl/fec_parity_enc.sv
module fec_parity_enc
    import fec_pkg::*;
#(
    parameter int               DATA_W = 64,
    parameter int               BLOCKS = 32,
    parameter int               PAR_W  = 26,
    parameter logic [PAR_W-1:0] POLY   = 26'h0220211
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    input  logic              mb_start,
    input  logic [DATA_W-1:0] blk_data,
    output logic              par_valid,
    output logic [PAR_W-1:0]  par_word
);

    logic             take, first, finish, in_mb, cnt_last;
    logic [PAR_W-1:0] rem_next, rem_q;

    fec_ctrl #(.BLOCKS(BLOCKS)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_valid (blk_valid),
        .mb_start  (mb_start),
        .cnt_last  (cnt_last),
        .take      (take),
        .first     (first),
        .finish    (finish),
        .in_mb     (in_mb)
    );

    fec_blk_counter #(.BLOCKS(BLOCKS)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (first),
        .finish   (finish),
        .cnt_last (cnt_last)
    );

    fec_remainder #(
        .DATA_W (DATA_W),
        .PAR_W  (PAR_W),
        .POLY   (POLY)
    ) i_rem (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .first    (first),
        .finish   (finish),
        .data     (blk_data),
        .rem_next (rem_next),
        .rem_q    (rem_q)
    );

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_valid <= 1'b0;
            par_word  <= '0;
        end else begin
            par_valid <= finish;
            if (finish) begin
                par_word <= rem_next;
            end
        end
    end

    // R2: remainder is back at zero whenever a word is released
    a_r2_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |-> (rem_q == '0));

    // R4: word only moves together with the strobe
    a_r4_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !par_valid |-> $stable(par_word));

    // R3: a released word closes the multiblock
    a_r3_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && !$past(blk_valid && mb_start)) |-> !in_mb);

    generate
        if (BLOCKS > 1) begin : g_pulse
            // R3: strobe is a single cycle
            a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                par_valid |=> !par_valid);
        end
    endgenerate

endmodule

// File: tb/test_fec_parity_enc.sv
module test_fec_parity_enc;

    localparam int DW = 64;
    localparam int NB = 32;
    localparam int PW = 26;
    localparam logic [PW:0] GFULL = 27'h4220211;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          blk_valid = 1'b0;
    logic          mb_start = 1'b0;
    logic [DW-1:0] blk_data = '0;
    logic          par_valid;
    logic [PW-1:0] par_word;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    bit          m_open = 0;
    int          m_cnt = 0;
    bit          q[$];
    bit          exp_valid = 0;
    bit [PW-1:0] exp_word = '0;
    bit [PW-1:0] last_word = '0;

    always #10 clk = ~clk;

    fec_parity_enc i_fec_parity_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_valid (blk_valid),
        .mb_start  (mb_start),
        .blk_data  (blk_data),
        .par_valid (par_valid),
        .par_word  (par_word)
    );

    function automatic bit [PW-1:0] long_div(input bit src[$]);
        bit w[$];
        bit [PW-1:0] r;
        w = src;
        for (int k = 0; k < PW; k++) w.push_back(1'b0);
        for (int i = 0; i + PW < w.size(); i++) begin
            if (w[i]) begin
                for (int j = 0; j <= PW; j++) w[i+j] ^= GFULL[PW-j];
            end
        end
        r = '0;
        for (int k = 0; k < PW; k++) r = {r[PW-2:0], w[w.size()-PW+k]};
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input bit v, input bit s, input logic [DW-1:0] d);
        exp_valid = 0;
        if (v && (s || m_open)) begin
            if (s) begin
                q.delete();
                m_cnt = 0;
            end
            for (int b = DW - 1; b >= 0; b--) q.push_back(d[b]);
            m_cnt++;
            m_open = 1;
            if (m_cnt == NB) begin
                exp_word  = long_div(q);
                exp_valid = 1;
                m_open    = 0;
                m_cnt     = 0;
                q.delete();
            end
        end
    endtask

    // one clock with the given inputs, then compare at the falling edge
    task automatic cyc(input bit v, input bit s, input logic [DW-1:0] d, input string tag);
        blk_valid = v;
        mb_start  = s;
        blk_data  = d;
        @(posedge clk);
        model_step(v, s, d);
        @(negedge clk);
        check(par_valid == exp_valid, "R3", "par_valid", {25'b0, par_valid}, {25'b0, exp_valid});
        if (exp_valid) begin
            check(par_word == exp_word, tag, "par_word", par_word, exp_word);
            last_word = exp_word;
        end else begin
            check(par_word == last_word, "R4", "par_word hold", par_word, last_word);
        end
    endtask

    task automatic send_mb(input int nblk, input int gap_every, input string tag);
        for (int b = 0; b < nblk; b++) begin
            if (gap_every > 0 && b % gap_every == 1)
                cyc(1'b0, ($urandom % 2) == 1, {$urandom, $urandom}, "R5");
            cyc(1'b1, b == 0, {$urandom, $urandom}, tag);
        end
    endtask

    initial begin
        int cycles = 0;
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                bad++;
                checks++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", checks, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [PW-1:0] first_par;
        repeat (3) @(negedge clk);
        // R9: reset values
        check(par_valid == 1'b0, "R9", "par_valid", {25'b0, par_valid}, '0);
        check(par_word == '0, "R9", "par_word", par_word, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: valid blocks with no open multiblock
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, {$urandom, $urandom}, "R7");
        // R8: start flag without a valid block, then more unflagged blocks
        cyc(1'b0, 1'b1, '1, "R8");
        for (int i = 0; i < 31; i++) cyc(1'b1, 1'b0, '1, "R8");
        cyc(1'b1, 1'b0, '1, "R8");

        // R1: all-zero multiblock
        for (int b = 0; b < NB; b++) cyc(1'b1, b == 0, '0, "R1");
        check(last_word == '0, "R1", "zero parity", last_word, '0);

        // R1: single one in the first transmitted bit
        for (int b = 0; b < NB; b++) cyc(1'b1, b == 0, (b == 0) ? {1'b1, 63'b0} : '0, "R1");
        // R1: single one in the last transmitted bit gives x^26 mod g
        for (int b = 0; b < NB; b++) cyc(1'b1, b == 0, (b == NB - 1) ? 64'd1 : '0, "R1");
        check(last_word == 26'h0220211, "R1", "last-bit parity", last_word, 26'h0220211);

        // R1: random payloads back to back
        for (int m = 0; m < 3; m++) send_mb(NB, 0, "R1");

        // R5: random payload with idle cycles scattered inside
        send_mb(NB, 5, "R5");

        // R6: restart after 10 blocks, and a restart on what would be block 32
        send_mb(10, 0, "R6");
        send_mb(NB, 0, "R6");
        send_mb(NB - 1, 0, "R6");
        send_mb(NB, 3, "R6");

        // R2: same payload twice after unrelated data gives the same word
        for (int b = 0; b < NB; b++) cyc(1'b1, b == 0, {32'hA5A5_0000 + b, 32'h1234_5678 ^ b}, "R2");
        first_par = last_word;
        send_mb(NB, 0, "R2");
        for (int b = 0; b < NB; b++) cyc(1'b1, b == 0, {32'hA5A5_0000 + b, 32'h1234_5678 ^ b}, "R2");
        check(last_word == first_par, "R2", "repeat parity", last_word, first_par);

        // R4: quiet cycles after release
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, {$urandom, $urandom}, "R4");

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule